// File: doc/BRIEF.md
# Fractional-Prescaler UART Baud Generator

This block produces the timing enables for a UART whose reference clock is fixed (nominally 62.5 MHz). The clock rate is reduced in three stages. First comes a fractional prescaler whose ratio is programmed in eighths, from 1.000 to 63.875. Next is a 16-bit integer divisor. Last is an oversampling counter with a ratio from 4 to 16. The divisor stage produces a one-clock sample enable. The oversampling stage marks every Nth sample enable as a bit enable. Shifters and FIFOs use these enables to time their work.

The settings are written through a small byte-wide write port. The prescaler is held as a 9-bit code in eighths, split over a low byte and a separate high bit. The high bit is cleared each time the low byte is written, so software writes the low byte first. The prescaler code can only be changed while an enhanced-mode bit is set. A separate enable bit chooses between the programmed prescaler and a divide-by-1 bypass. After reset the code is 271 (33.875) and oversampling is 16. With these values, legacy divisor values produce the expected bit rates once the prescaler is enabled.

The fractional division uses an accumulator. Each clock adds 8. When the sum reaches the code, the code is subtracted and one prescaled enable is emitted. Any write to a defined register restarts all counters, so no shortened period follows a rate change.

Top module: `frac_baud_gen`

## Requirements
- R1: During reset both ticks are low. After reset the divisor is 1, the oversampling register is 0 (meaning 16), the prescaler code is 271, and both the enhanced-mode bit and the prescaler-enable bit are clear.
- R2: The write addresses are as follows. 0 is divisor bits 7:0. 1 is divisor bits 15:8. 2 is the oversampling register. 3 is prescaler code bits 7:0. 4 is prescaler code bit 8, taken from data bit 0. 5 is the feature register, where data bit 4 is the enhanced-mode bit. 6 is the mode register, where data bit 7 is the prescaler enable. A write to address 7 changes nothing and does not disturb the ticks.
- R3: With the prescaler enabled and an effective code P (in eighths), exactly 8 prescaled enables occur in every P clocks. As a result, eight consecutive sample-tick intervals together span D*P clocks, where D is the effective divisor.
- R4: Writes to addresses 3 and 4 are ignored while the enhanced-mode bit is clear.
- R5: A write to address 3 while enhanced mode is set clears prescaler code bit 8.
- R6: While the prescaler enable is clear, the prescaler divides by 1 (P = 8). Codes below 8 are treated as 8.
- R7: The sample tick is high for one clock after every D prescaled enables. A divisor value of 0 is treated as 1.
- R8: The bit tick is high together with every Nth sample tick. An oversampling register of 0 or above 16 gives N = 16, values 1 to 3 give N = 4, and values 4 to 16 give that value.
- R9: A write to any of addresses 0 to 6 restarts all counters. With P = 8, the first sample tick is high D+1 clocks after the write edge, and the first bit tick is high N*D+1 clocks after it. No shortened tick appears in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| sample_tick | output | 1 | One-clock oversampling enable |
| bit_tick | output | 1 | One-clock bit enable, coincident with a sample tick |

## Verification
A wrong accumulator remainder or prescaler code shows as a wrong sample-tick spacing. It appears within one pattern of eight sample intervals, each of which should span exactly D*P clocks. A stale divisor or oversampling count shows in the first tick after a write, because restarted counters give a fixed latency of D+1 clocks to the first sample tick and N*D+1 clocks to the first bit tick. A high code bit that is wrongly kept or wrongly cleared shifts the measured span by 256*D clocks, which makes it plainly visible.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int PSC_ONE   = 8;      // code for a ratio of 1.000
    localparam int ENH_BIT   = 4;
    localparam int PEN_BIT   = 7;

    typedef enum logic [ADDR_W-1:0] {
        A_DIV_LO = 3'd0,
        A_DIV_HI = 3'd1,
        A_OVS    = 3'd2,
        A_PSC_LO = 3'd3,
        A_PSC_HI = 3'd4,
        A_FEAT   = 3'd5,
        A_MODE   = 3'd6
    } reg_addr_e;

    localparam int LAST_ADDR = 6;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PSC_W     = 9,
    parameter int OVS_W     = 5,
    parameter int OVS_MIN   = 4,
    parameter int OVS_MAX   = 16,
    parameter int PSC_RESET = 271
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_eff,
    output logic [PSC_W-1:0]  psc_eff,
    output logic [OVS_W-1:0]  ovs_eff,
    output logic              reload
);
    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] ovs;
        logic [PSC_W-1:0]  psc;
        logic              enh;
        logic              pen;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        reload = wr_en && (wr_addr <= ADDR_W'(LAST_ADDR));
        if (wr_en) begin
            case (wr_addr)
                ADDR_W'(A_DIV_LO): r_d.div[7:0]         = wr_data;
                ADDR_W'(A_DIV_HI): r_d.div[DIV_W-1:8]   = wr_data[DIV_W-9:0];
                ADDR_W'(A_OVS):    r_d.ovs              = wr_data;
                ADDR_W'(A_PSC_LO): if (r_q.enh) r_d.psc = {1'b0, wr_data[PSC_W-2:0]};
                ADDR_W'(A_PSC_HI): if (r_q.enh) r_d.psc[PSC_W-1] = wr_data[0];
                ADDR_W'(A_FEAT):   r_d.enh              = wr_data[ENH_BIT];
                ADDR_W'(A_MODE):   r_d.pen              = wr_data[PEN_BIT];
                default: ;
            endcase
        end

        div_eff = (r_q.div == '0) ? DIV_W'(1) : r_q.div;

        if (!r_q.pen || (r_q.psc < PSC_W'(PSC_ONE)))
            psc_eff = PSC_W'(PSC_ONE);
        else
            psc_eff = r_q.psc;

        if ((r_q.ovs == '0) || (r_q.ovs > DATA_W'(OVS_MAX)))
            ovs_eff = OVS_W'(OVS_MAX);
        else if (r_q.ovs < DATA_W'(OVS_MIN))
            ovs_eff = OVS_W'(OVS_MIN);
        else
            ovs_eff = OVS_W'(r_q.ovs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.div <= DIV_W'(1);
            r_q.ovs <= '0;
            r_q.psc <= PSC_W'(PSC_RESET);
            r_q.enh <= 1'b0;
            r_q.pen <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R4: prescaler code is locked outside enhanced mode
    p_psc_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !r_q.enh && (wr_addr == ADDR_W'(A_PSC_LO) || wr_addr == ADDR_W'(A_PSC_HI)))
        |=> (r_q.psc == $past(r_q.psc)));

    // R5: low-byte write clears the top code bit
    p_lo_clears_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.enh && wr_addr == ADDR_W'(A_PSC_LO)) |=> (r_q.psc[PSC_W-1] == 1'b0));

    // R8: effective oversampling ratio stays in range
    p_ovs_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovs_eff >= OVS_W'(OVS_MIN)) && (ovs_eff <= OVS_W'(OVS_MAX)));
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
#(
    parameter int PSC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [PSC_W-1:0] psc_eff,
    output logic             pre_en
);
    localparam int ACC_W = PSC_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pre;
    } psc_state_t;

    psc_state_t s_d, s_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = s_q.acc + ACC_W'(PSC_ONE);
        if (reload) begin
            s_d.acc = '0;
            s_d.pre = 1'b0;
        end else if (sum >= {1'b0, psc_eff}) begin
            s_d.acc = sum - {1'b0, psc_eff};
            s_d.pre = 1'b1;
        end else begin
            s_d.acc = sum;
            s_d.pre = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pre_en = s_q.pre;

    // R3: remainder always below the code in force
    p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.acc < {1'b0, psc_eff});

    // R9: restart leaves no pending enable
    p_pre_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !pre_en);
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div_eff,
    output logic             smp
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             smp;
    } div_state_t;

    div_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.smp = 1'b0;
        if (reload) begin
            s_d.cnt = '0;
        end else if (pre_en) begin
            if (s_q.cnt >= div_eff - DIV_W'(1)) begin
                s_d.cnt = '0;
                s_d.smp = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign smp = s_q.smp;

    // R7: count never passes the terminal value
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < div_eff);

    // R9: no runt sample tick right after a restart
    p_no_runt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !smp);

    // R7: a sample tick only follows a prescaled enable
    p_smp_after_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> $past(pre_en));
endmodule

// File: rtl/baud_oversampler.sv
module baud_oversampler #(
    parameter int OVS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             smp,
    input  logic [OVS_W-1:0] ovs_eff,
    output logic             bit_en
);
    typedef struct packed {
        logic [OVS_W-1:0] cnt;
    } ovs_state_t;

    ovs_state_t s_d, s_q;
    logic       last;

    always_comb begin
        s_d  = s_q;
        last = (s_q.cnt >= ovs_eff - OVS_W'(1));
        if (reload) begin
            s_d.cnt = '0;
        end else if (smp) begin
            s_d.cnt = last ? '0 : s_q.cnt + OVS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_en = smp && last;

    // R8: bit tick only together with a sample tick
    p_bit_on_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |-> smp);

    // R8: sample count stays below the ratio
    p_ovs_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < ovs_eff);
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int DIV_W     = 16,
    parameter int PSC_W     = 9,
    parameter int OVS_MIN   = 4,
    parameter int OVS_MAX   = 16,
    parameter int PSC_RESET = 271
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);
    localparam int OVS_W = $clog2(OVS_MAX + 1);

    logic [DIV_W-1:0] div_eff;
    logic [PSC_W-1:0] psc_eff;
    logic [OVS_W-1:0] ovs_eff;
    logic             reload;
    logic             pre_en;

    baud_regs #(
        .DIV_W(DIV_W), .PSC_W(PSC_W), .OVS_W(OVS_W),
        .OVS_MIN(OVS_MIN), .OVS_MAX(OVS_MAX), .PSC_RESET(PSC_RESET)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_eff(div_eff), .psc_eff(psc_eff),
        .ovs_eff(ovs_eff), .reload(reload)
    );

    baud_prescaler #(.PSC_W(PSC_W)) i_psc (
        .clk(clk), .rst_n(rst_n), .reload(reload),
        .psc_eff(psc_eff), .pre_en(pre_en)
    );

    baud_divider #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .reload(reload), .pre_en(pre_en),
        .div_eff(div_eff), .smp(sample_tick)
    );

    baud_oversampler #(.OVS_W(OVS_W)) i_ovs (
        .clk(clk), .rst_n(rst_n), .reload(reload), .smp(sample_tick),
        .ovs_eff(ovs_eff), .bit_en(bit_tick)
    );

    // R1: ticks stay low while reset is held
    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!sample_tick && !bit_tick);
        end
    end
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sample_tick;
    logic       bit_tick;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int sh_div = 1;
    int sh_ovs = 0;
    int sh_psc = 271;
    bit sh_enh = 1'b0;
    bit sh_pen = 1'b0;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int eff_div();
        return (sh_div == 0) ? 1 : sh_div;
    endfunction

    function automatic int eff_psc();
        if (!sh_pen || sh_psc < 8) return 8;
        return sh_psc;
    endfunction

    function automatic int eff_ovs();
        if (sh_ovs == 0 || sh_ovs > 16) return 16;
        if (sh_ovs < 4) return 4;
        return sh_ovs;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk = n_chk + 1;
        if (got != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(addr);
        wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        case (addr)
            0: sh_div = (sh_div & 32'hff00) | (data & 8'hff);
            1: sh_div = (sh_div & 32'h00ff) | ((data & 8'hff) << 8);
            2: sh_ovs = data & 8'hff;
            3: if (sh_enh) sh_psc = data & 8'hff;
            4: if (sh_enh) sh_psc = (sh_psc & 8'hff) | ((data & 1) << 8);
            5: sh_enh = data[4];
            6: sh_pen = data[7];
            default: ;
        endcase
    endtask

    // clocks from the write edge to the first tick of the chosen kind
    task automatic first_tick(input bit use_bit, output int n);
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk); #1;
            n = n + 1;
            if (use_bit ? bit_tick : sample_tick) return;
        end
        n = -1;
    endtask

    // clocks spanned by m intervals of the chosen tick
    task automatic span(input bit use_bit, input int m, output int n);
        int seen;
        n = -1;
        for (int k = 0; k < 40000; k++) begin
            @(posedge clk); #1;
            if (use_bit ? bit_tick : sample_tick) begin
                n = 0;
                break;
            end
        end
        if (n < 0) return;
        seen = 0;
        for (int k = 0; k < 60000; k++) begin
            @(posedge clk); #1;
            n = n + 1;
            if (use_bit ? bit_tick : sample_tick) begin
                seen = seen + 1;
                if (seen == m) return;
            end
        end
        n = -1;
    endtask

    initial begin
        int got;
        int zero_ticks;
        void'($urandom(32'd20240611));

        // R1: reset quiet
        zero_ticks = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) zero_ticks = zero_ticks + 1;
        end
        check("R1 ticks during reset", zero_ticks, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: defaults, prescaler bypassed, divisor 1, N 16
        span(1'b0, 8, got);
        check("R1 default sample span", got, 8);
        span(1'b1, 8, got);
        check("R1 default bit span", got, 128);

        // R1/R6: enable prescaler, reset code 271
        wr(6, 8'h80);
        span(1'b0, 8, got);
        check("R1 reset code 271", got, 271);

        // R4: locked outside enhanced mode
        wr(3, 8'h10);
        span(1'b0, 8, got);
        check("R4 write ignored", got, 271);

        // R2: address 7 has no effect
        wr(7, 8'h00);
        span(1'b0, 8, got);
        check("R2 addr 7 ignored", got, 271);

        // R3: enhanced mode, code 16
        wr(5, 8'h10);
        wr(3, 8'h10);
        span(1'b0, 8, got);
        check("R3 code 16", got, 16);

        // R2: high code bit
        wr(3, 8'h20);
        wr(4, 8'h01);
        span(1'b0, 8, got);
        check("R2 code 288", got, 288);

        // R5: low write clears high bit
        wr(3, 8'h20);
        span(1'b0, 8, got);
        check("R5 code back to 32", got, 32);

        // R6: clamp below 8
        wr(3, 8'h03);
        span(1'b0, 8, got);
        check("R6 clamp", got, 8);

        // R6: bypass with enable clear
        wr(3, 8'd40);
        wr(6, 8'h00);
        span(1'b0, 8, got);
        check("R6 bypass", got, 8);

        // R7: divisor 0 acts as 1, divisor 5, high byte
        wr(0, 8'h00);
        span(1'b0, 8, got);
        check("R7 divisor zero", got, 8);
        wr(0, 8'h05);
        span(1'b0, 8, got);
        check("R7 divisor 5", got, 40);
        wr(0, 8'h00);
        wr(1, 8'h01);
        span(1'b0, 8, got);
        check("R2 divisor 256", got, 2048);
        wr(1, 8'h00);
        wr(0, 8'h01);

        // R8: oversampling decode
        wr(2, 8'd0);
        span(1'b1, 8, got);
        check("R8 ovs 0", got, 128);
        wr(2, 8'd2);
        span(1'b1, 8, got);
        check("R8 ovs 2 max rate", got, 32);
        wr(2, 8'd20);
        span(1'b1, 8, got);
        check("R8 ovs 20", got, 128);
        wr(2, 8'd9);
        span(1'b1, 8, got);
        check("R8 ovs 9", got, 72);

        // R9: restart latency
        wr(2, 8'd5);
        wr(0, 8'd3);
        first_tick(1'b0, got);
        check("R9 first sample", got, 4);
        wr(2, 8'd5);
        first_tick(1'b1, got);
        check("R9 first bit", got, 16);

        // R3/R7/R8: random settings with prescaler on
        for (int t = 0; t < 16; t++) begin
            int d, p, o;
            d = 1 + int'($urandom_range(0, 5));
            p = 8 + int'($urandom_range(0, 32));
            o = int'($urandom_range(0, 20));
            wr(5, 8'h10);
            wr(3, p);
            wr(4, 0);
            wr(0, d);
            wr(1, 0);
            wr(2, o);
            wr(6, ($urandom_range(0, 3) != 0) ? 8'h80 : 8'h00);
            span(1'b0, 8, got);
            check("R3 random sample span", got, eff_div() * eff_psc());
            span(1'b1, 8, got);
            check("R8 random bit span", got, eff_ovs() * eff_div() * eff_psc());
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule